// File: doc/BRIEF.md
# DRAM Strobe-Driven Refresh and Self-Refresh Controller

This block sits on the refresh-control side of an asynchronous single-bit DRAM model. It samples the active-low row and column strobes on a system clock and sorts each strobe cycle into one of three kinds. When the column strobe goes low first, the cycle is a counter refresh. When the row strobe goes low first, the cycle is a row-addressed refresh. When the column strobe goes low and comes back without any row strobe, the cycle is abandoned. A counter refresh uses the row held in an internal wrap-around row counter and then advances that counter. A row-addressed refresh uses the row presented on `row_addr_in` and leaves the counter alone.

If both strobes stay low after a counter refresh for `ENTRY_CYCLES` clocks (100 µs at the default 100 MHz), the block enters self-refresh. An internal timer then issues a counter refresh every `SELF_PERIOD` clocks. Self-refresh ends only after both strobes have been high for `EXIT_HOLD` consecutive clocks. Leaving self-refresh raises an obligation flag. That flag stays set until refreshes of any kind have covered every row index. Each refresh appears as a one-clock `refresh_pulse` together with the row it refreshed.

The state machine has seven states:
- `ST_IDLE` has both strobes high.
  - Row strobe low goes to `ST_ROW_ACT`, with a row-addressed refresh.
  - Column strobe low alone goes to `ST_COL_FIRST`.
- `ST_COL_FIRST`:
  - Column strobe high goes back to `ST_IDLE`, an abandoned cycle.
  - Row strobe low goes to `ST_CBR_HOLD`, with a counter refresh.
- `ST_CBR_HOLD`:
  - Both strobes high goes to `ST_IDLE`.
  - One strobe high goes to `ST_DRAIN`.
  - The entry count expiring goes to `ST_SELF`.
- `ST_SELF` fires a timed counter refresh each period. Both strobes high goes to `ST_EXIT_HOLD`.
- `ST_EXIT_HOLD`:
  - Either strobe low goes back to `ST_SELF`.
  - The hold count expiring goes to `ST_IDLE` and sets the obligation flag.
- `ST_ROW_ACT` leaves when the row strobe rises: to `ST_IDLE` if the column strobe is high, otherwise to `ST_DRAIN`.
- `ST_DRAIN` waits for both strobes high, then goes to `ST_IDLE`.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the row counter, `refresh_pulse`, `refresh_row`, `in_self_refresh` and `burst_owed`, and returns to `ST_IDLE`.
- R2: If the column strobe falls and the row strobe then falls, one refresh of the current counter row is issued. The counter then advances by one, wrapping from ROWS-1 to 0.
- R3: If the column strobe falls and rises again while the row strobe stays high, no refresh is issued and the counter is unchanged.
- R4: If the row strobe falls while idle, one refresh of `row_addr_in` is issued and the counter is unchanged.
- R5: `in_self_refresh` rises on the (ENTRY_CYCLES+1)-th clock at which both strobes are sampled low after a counter refresh. It does not rise earlier.
- R6: While in self-refresh, a counter refresh fires every SELF_PERIOD clocks without any external address, on consecutive counter rows.
- R7: Self-refresh ends only after both strobes are sampled high for EXIT_HOLD+1 consecutive clocks. Any strobe sampled low before that keeps the block in self-refresh.
- R8: Leaving self-refresh sets `burst_owed` on the same clock on which `in_self_refresh` clears.
- R9: `burst_owed` clears only when refreshes of any kind since the exit have covered every row index 0 to ROWS-1. Repeated rows do not count twice.
- R10: `refresh_pulse` is high for exactly one clock per refresh, and `refresh_row` holds the row of the latest refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| row_strobe_n | input | 1 | Active-low row strobe |
| col_strobe_n | input | 1 | Active-low column strobe |
| row_addr_in | input | ROW_W | Row for row-first refresh cycles |
| refresh_pulse | output | 1 | One-clock pulse per refresh |
| refresh_row | output | ROW_W | Row of the latest refresh |
| in_self_refresh | output | 1 | Self-refresh active |
| burst_owed | output | 1 | Full-array refresh still owed after exit |

## Verification
The bench drives a table of strobe patterns: short column-first cycles, row-first cycles with chosen addresses, and abandoned column-only cycles. Together these separate counter-addressed refreshes from externally addressed refreshes and from cycles that must produce nothing. Self-refresh entry is probed one clock before and at the threshold. Exit is tried with a strobe that drops one clock short of the hold time, which shows that a brief return to high does not count as an exit. The burst obligation is exercised with a repeated row that must not clear it, followed by the last missing row that must. Counter wrap-around and reset mid-run close the run.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COL_FIRST,
        ST_CBR_HOLD,
        ST_SELF,
        ST_EXIT_HOLD,
        ST_ROW_ACT,
        ST_DRAIN
    } ref_state_t;
endpackage

// File: rtl/dram_ref_tick_counter.sv
module dram_ref_tick_counter #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    output logic hit
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign hit = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= hit ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dram_ref_row_counter.sv
module dram_ref_row_counter #(
    parameter int ROWS  = 64,
    parameter int ROW_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
        end else if (advance) begin
            row <= (row == LAST_ROW) ? '0 : row + 1'b1;
        end
    end
endmodule

// File: rtl/dram_ref_burst_tracker.sv
module dram_ref_burst_tracker #(
    parameter int ROWS  = 64,
    parameter int ROW_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             hit,
    input  logic [ROW_W-1:0] hit_row,
    output logic             owed
);
    logic [ROWS-1:0] seen_q;
    logic [ROWS-1:0] hit_vec;
    logic            covered;

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        assign hit_vec[i] = hit && (hit_row == ROW_W'(i));
        always_ff @(posedge clk) begin
            if (rst || arm) begin
                seen_q[i] <= 1'b0;
            end else if (owed && hit_vec[i]) begin
                seen_q[i] <= 1'b1;
            end
        end
    end

    assign covered = &(seen_q | hit_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= 1'b0;
        end else if (arm) begin
            owed <= 1'b1;
        end else if (owed && hit && covered) begin
            owed <= 1'b0;
        end
    end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import dram_ref_pkg::*;
#(
    parameter int ROWS         = 64,
    parameter int ENTRY_CYCLES = 10000,
    parameter int SELF_PERIOD  = 1560,
    parameter int EXIT_HOLD    = 10,
    localparam int ROW_W       = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             row_strobe_n,
    input  logic             col_strobe_n,
    input  logic [ROW_W-1:0] row_addr_in,
    output logic             refresh_pulse,
    output logic [ROW_W-1:0] refresh_row,
    output logic             in_self_refresh,
    output logic             burst_owed
);
    ref_state_t state_q, state_d;

    logic both_low, both_high;
    logic hold_hit, self_hit, exit_hit;
    logic fire_cbr, fire_ror, fire_any, arm_burst;
    logic [ROW_W-1:0] cnt_row, fire_row;

    assign both_low  = !row_strobe_n && !col_strobe_n;
    assign both_high = row_strobe_n && col_strobe_n;

    dram_ref_tick_counter #(.LIMIT(ENTRY_CYCLES)) u_entry_cnt (
        .clk (clk),
        .rst (rst),
        .clr (state_q != ST_CBR_HOLD),
        .en  ((state_q == ST_CBR_HOLD) && both_low),
        .hit (hold_hit)
    );

    dram_ref_tick_counter #(.LIMIT(SELF_PERIOD)) u_self_timer (
        .clk (clk),
        .rst (rst),
        .clr (state_q != ST_SELF),
        .en  ((state_q == ST_SELF) && !both_high),
        .hit (self_hit)
    );

    dram_ref_tick_counter #(.LIMIT(EXIT_HOLD)) u_exit_cnt (
        .clk (clk),
        .rst (rst),
        .clr (state_q != ST_EXIT_HOLD),
        .en  ((state_q == ST_EXIT_HOLD) && both_high),
        .hit (exit_hit)
    );

    dram_ref_row_counter #(.ROWS(ROWS), .ROW_W(ROW_W)) u_row_cnt (
        .clk     (clk),
        .rst     (rst),
        .advance (fire_cbr),
        .row     (cnt_row)
    );

    assign fire_any = fire_cbr || fire_ror;
    assign fire_row = fire_ror ? row_addr_in : cnt_row;

    dram_ref_burst_tracker #(.ROWS(ROWS), .ROW_W(ROW_W)) u_burst (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm_burst),
        .hit     (fire_any),
        .hit_row (fire_row),
        .owed    (burst_owed)
    );

    always_comb begin
        state_d   = state_q;
        fire_cbr  = 1'b0;
        fire_ror  = 1'b0;
        arm_burst = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!row_strobe_n) begin
                    state_d  = ST_ROW_ACT;
                    fire_ror = 1'b1;
                end else if (!col_strobe_n) begin
                    state_d = ST_COL_FIRST;
                end
            end
            ST_COL_FIRST: begin
                if (col_strobe_n) begin
                    state_d = ST_IDLE;
                end else if (!row_strobe_n) begin
                    state_d  = ST_CBR_HOLD;
                    fire_cbr = 1'b1;
                end
            end
            ST_CBR_HOLD: begin
                if (both_high)      state_d = ST_IDLE;
                else if (!both_low) state_d = ST_DRAIN;
                else if (hold_hit)  state_d = ST_SELF;
            end
            ST_SELF: begin
                if (both_high)     state_d  = ST_EXIT_HOLD;
                else if (self_hit) fire_cbr = 1'b1;
            end
            ST_EXIT_HOLD: begin
                if (!both_high) begin
                    state_d = ST_SELF;
                end else if (exit_hit) begin
                    state_d   = ST_IDLE;
                    arm_burst = 1'b1;
                end
            end
            ST_ROW_ACT: begin
                if (row_strobe_n) state_d = col_strobe_n ? ST_IDLE : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (both_high) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            refresh_pulse   <= 1'b0;
            refresh_row     <= '0;
            in_self_refresh <= 1'b0;
        end else begin
            refresh_pulse   <= fire_any;
            if (fire_any) refresh_row <= fire_row;
            in_self_refresh <= (state_d == ST_SELF) || (state_d == ST_EXIT_HOLD);
        end
    end
endmodule

// File: rtl/dram_refresh_ctrl_checker.sv
module dram_refresh_ctrl_checker (
    input logic clk,
    input logic rst,
    input logic row_strobe_n,
    input logic col_strobe_n,
    input logic refresh_pulse,
    input logic in_self_refresh,
    input logic burst_owed
);
    p_pulse_one_clock_r10: assert property (@(posedge clk) disable iff (rst)
        refresh_pulse |=> !refresh_pulse);

    p_entry_strobes_low_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(in_self_refresh)) |-> $past(!row_strobe_n && !col_strobe_n));

    p_exit_strobes_high_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(in_self_refresh)) |-> $past(row_strobe_n && col_strobe_n));

    p_exit_sets_owed_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(in_self_refresh)) |-> burst_owed);

    p_owed_clears_on_refresh_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(burst_owed)) |-> refresh_pulse);
endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .row_strobe_n    (row_strobe_n),
    .col_strobe_n    (col_strobe_n),
    .refresh_pulse   (refresh_pulse),
    .in_self_refresh (in_self_refresh),
    .burst_owed      (burst_owed)
);

// File: tb/dram_refresh_ctrl_bench.sv
module dram_refresh_ctrl_bench;
    localparam int ROWS   = 8;
    localparam int ENTRY  = 20;
    localparam int PERIOD = 5;
    localparam int HOLD   = 4;
    localparam int RW     = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1;
    logic cas_n = 1'b1;
    logic [RW-1:0] addr = '0;
    logic refresh_pulse, in_self_refresh, burst_owed;
    logic [RW-1:0] refresh_row;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int doubles = 0;
    bit prev_pulse = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dram_refresh_ctrl #(
        .ROWS(ROWS), .ENTRY_CYCLES(ENTRY), .SELF_PERIOD(PERIOD), .EXIT_HOLD(HOLD)
    ) u_dram_refresh_ctrl (
        .clk(clk), .rst(rst), .row_strobe_n(ras_n), .col_strobe_n(cas_n),
        .row_addr_in(addr), .refresh_pulse(refresh_pulse), .refresh_row(refresh_row),
        .in_self_refresh(in_self_refresh), .burst_owed(burst_owed)
    );

    always @(negedge clk) begin
        if (refresh_pulse) pulses++;
        if (refresh_pulse && prev_pulse) doubles++;
        prev_pulse = refresh_pulse;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cbr_cycle();
        cas_n = 1'b0; step(1);
        ras_n = 1'b0; step(2);
        ras_n = 1'b1; cas_n = 1'b1; step(2);
    endtask

    task automatic ror_cycle(input int a);
        addr = RW'(a);
        ras_n = 1'b0; step(2);
        ras_n = 1'b1; step(2);
    endtask

    task automatic abort_cycle();
        cas_n = 1'b0; step(2);
        cas_n = 1'b1; step(2);
    endtask

    // {kind[7:6], addr[5:3], expected row[2:0]}; kind 0 column-first, 1 row-first, 2 abandoned
    localparam logic [7:0] VEC [5] = '{
        {2'd0, 3'd0, 3'd0},
        {2'd0, 3'd0, 3'd1},
        {2'd1, 3'd5, 3'd5},
        {2'd2, 3'd0, 3'd5},
        {2'd0, 3'd0, 3'd2}
    };

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 pulse after reset", int'(refresh_pulse), 0);
        chk("R1 self flag after reset", int'(in_self_refresh), 0);
        chk("R1 burst flag after reset", int'(burst_owed), 0);
        chk("R1 row after reset", int'(refresh_row), 0);

        for (int i = 0; i < 5; i++) begin
            base = pulses;
            case (VEC[i][7:6])
                2'd0: cbr_cycle();
                2'd1: ror_cycle(int'(VEC[i][5:3]));
                default: abort_cycle();
            endcase
            if (VEC[i][7:6] == 2'd2) begin
                chk("R3 no refresh on abandoned cycle", pulses - base, 0);
            end else begin
                chk("R2/R4 one refresh per cycle", pulses - base, 1);
                chk(VEC[i][7:6] == 2'd0 ? "R2 counter row" : "R4 external row",
                    int'(refresh_row), int'(VEC[i][2:0]));
            end
        end

        // Self-refresh entry boundary
        base = pulses;
        cas_n = 1'b0; step(1);
        ras_n = 1'b0; step(ENTRY);
        chk("R5 not yet in self-refresh", int'(in_self_refresh), 0);
        chk("R2 entry refresh row", int'(refresh_row), 3);
        step(1);
        chk("R5 in self-refresh", int'(in_self_refresh), 1);
        base = pulses;
        step(3 * PERIOD);
        chk("R6 timed refresh count", pulses - base, 3);
        chk("R6 timed refresh row", int'(refresh_row), 6);
        chk("R8 no burst owed yet", int'(burst_owed), 0);

        // Exit hold interrupted one clock short
        ras_n = 1'b1; cas_n = 1'b1; step(HOLD);
        ras_n = 1'b0; cas_n = 1'b0; step(2);
        chk("R7 short high keeps self-refresh", int'(in_self_refresh), 1);
        ras_n = 1'b1; cas_n = 1'b1; step(HOLD);
        chk("R7 still in self before hold ends", int'(in_self_refresh), 1);
        step(1);
        chk("R7 self-refresh exited", int'(in_self_refresh), 0);
        chk("R8 burst owed after exit", int'(burst_owed), 1);

        // Burst coverage
        for (int r = 0; r < ROWS - 1; r++) ror_cycle(r);
        ror_cycle(0);
        chk("R9 owed with one row missing", int'(burst_owed), 1);
        ror_cycle(ROWS - 1);
        chk("R9 owed clears when all rows seen", int'(burst_owed), 0);

        // Counter wrap
        cbr_cycle();
        chk("R2 last counter row", int'(refresh_row), 7);
        cbr_cycle();
        chk("R2 counter wraps to zero", int'(refresh_row), 0);

        chk("R10 no pulse wider than one clock", doubles, 0);

        // Reset in the middle of activity
        cbr_cycle();
        rst = 1'b1; step(2);
        rst = 1'b0; step(1);
        chk("R1 row cleared by reset", int'(refresh_row), 0);
        cbr_cycle();
        chk("R1 counter restarts at zero", int'(refresh_row), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule